// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a multicycle processor datapath in which instructions and data share one memory. Each instruction passes through a common fetch cycle and a decode/register-read cycle, then through one to three further states picked by its instruction class: memory access, register-to-register arithmetic, conditional branch or jump. Every datapath steering and write-enable signal is a pure function of the current state (Moore outputs). Only the next-state choice looks at the opcode and at the ALU overflow flag.

Two exception states are built in. An opcode that matches no known class, or an overflow reported while an arithmetic result is being written back, sends the sequencer to a state that records a cause code, stores the faulting PC (the ALU is set up to produce PC minus 4) and loads the PC with the handler address through the fourth PC source. The sequencer then returns to fetch.

Top module: `mcc_top`

## Requirements
- R1: A high `rst` at a rising clock edge forces the sequencer to state 0 (fetch), from any state. The state is visible on `state_o`.
- R2: State 0 drives `mem_rd`=1, `ir_load`=1, `alu_b_sel`=01, `pc_load`=1 and `pc_src`=00, with every other output 0. The next state is always 1.
- R3: State 1 drives `alu_b_sel`=11 with every other output 0. It then dispatches on the opcode: 100011 (load) or 101011 (store) to state 2, 000000 (register arithmetic) to state 6, 000100 (branch-if-equal) to state 8, 000010 (jump) to state 9.
- R4: State 2 drives `alu_a_sel`=1 and `alu_b_sel`=10. It goes to state 3 for a load and to state 5 for a store.
- R5: State 3 drives `mem_rd`=1 and `mem_addr_sel`=1, then goes to state 4. State 4 drives `reg_wr`=1 and `wb_from_mem`=1, then goes to state 0.
- R6: State 5 drives `mem_wr`=1 and `mem_addr_sel`=1, then goes to state 0.
- R7: State 6 drives `alu_a_sel`=1 and `alu_mode`=10, then goes to state 7. State 7 drives `reg_wr`=1 and `dst_is_rd`=1, then goes to state 0 when `overflow` is 0.
- R8: `overflow`=1 in state 7 leads to state 11. In every other state `overflow` has no effect on the sequence.
- R9: State 8 drives `alu_a_sel`=1, `alu_mode`=01, `pc_load_if_zero`=1 and `pc_src`=01, then goes to state 0.
- R10: State 9 drives `pc_load`=1 and `pc_src`=10, then goes to state 0.
- R11: Any other opcode in state 1 leads to state 10. State 10 drives `cause_load`=1, `cause_code`=0, `epc_load`=1, `pc_load`=1, `pc_src`=11, `alu_b_sel`=01 and `alu_mode`=01, then goes to state 0.
- R12: State 11 drives the same outputs as state 10, except that `cause_code`=1, then goes to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| overflow | input | 1 | ALU overflow flag |
| state_o | output | 4 | Current state number |
| mem_addr_sel | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from memory data register |
| dst_is_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| reg_wr | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_zero | output | 1 | PC write when ALU zero flag is set |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler address |
| epc_load | output | 1 | Exception PC register write |
| cause_load | output | 1 | Cause register write |
| cause_code | output | 1 | Cause value: 0 undefined opcode, 1 overflow |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the five class encodings listed in R3. These make every class path reachable by opcode value alone, including the load and store split in state 2. Two opcodes outside the known set, 111111 and 001000, reach the undefined-opcode state. Overflow is raised both during a register-arithmetic instruction and during a load, which covers both the exception branch and the cases where the flag must be ignored.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_ADDR   = 4'd2,
        S_LDMEM  = 4'd3,
        S_LDWB   = 4'd4,
        S_STMEM  = 4'd5,
        S_EXEC   = 4'd6,
        S_RWB    = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9,
        S_BADOP  = 4'd10,
        S_OVF    = 4'd11
    } state_e;

    typedef enum logic [2:0] {
        C_RTYPE,
        C_LOAD,
        C_STORE,
        C_BEQ,
        C_JUMP,
        C_OTHER
    } iclass_e;

    localparam logic [1:0] BSEL_REG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM  = 2'b10;
    localparam logic [1:0] BSEL_SHF  = 2'b11;

    localparam logic [1:0] AMODE_ADD = 2'b00;
    localparam logic [1:0] AMODE_SUB = 2'b01;
    localparam logic [1:0] AMODE_FN  = 2'b10;

    localparam logic [1:0] PCS_ALU = 2'b00;
    localparam logic [1:0] PCS_OUT = 2'b01;
    localparam logic [1:0] PCS_JMP = 2'b10;
    localparam logic [1:0] PCS_EXC = 2'b11;

    typedef struct packed {
        logic       mem_addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_load;
        logic       wb_from_mem;
        logic       dst_is_rd;
        logic       reg_wr;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_mode;
        logic       pc_load;
        logic       pc_load_if_zero;
        logic [1:0] pc_src;
        logic       epc_load;
        logic       cause_load;
        logic       cause_code;
    } ctl_t;

    typedef struct packed {
        state_e st;
    } seq_t;

endpackage

// File: rtl/mcc_class_dec.sv
module mcc_class_dec
    import mcc_pkg::*;
#(
    parameter int             OP_W     = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output iclass_e         iclass
);
    always_comb begin
        if (opcode == OP_RTYPE)      iclass = C_RTYPE;
        else if (opcode == OP_LOAD)  iclass = C_LOAD;
        else if (opcode == OP_STORE) iclass = C_STORE;
        else if (opcode == OP_BEQ)   iclass = C_BEQ;
        else if (opcode == OP_JUMP)  iclass = C_JUMP;
        else                         iclass = C_OTHER;
    end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e  cur,
    input  iclass_e iclass,
    input  logic    overflow,
    output state_e  nxt
);
    always_comb begin
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                unique case (iclass)
                    C_LOAD, C_STORE: nxt = S_ADDR;
                    C_RTYPE:         nxt = S_EXEC;
                    C_BEQ:           nxt = S_BRANCH;
                    C_JUMP:          nxt = S_JUMP;
                    default:         nxt = S_BADOP;
                endcase
            end
            S_ADDR:   nxt = (iclass == C_STORE) ? S_STMEM : S_LDMEM;
            S_LDMEM:  nxt = S_LDWB;
            S_EXEC:   nxt = S_RWB;
            S_RWB:    nxt = overflow ? S_OVF : S_FETCH;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_out_dec.sv
module mcc_out_dec
    import mcc_pkg::*;
(
    input  state_e cur,
    output ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            S_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_load   = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_mode  = AMODE_ADD;
                ctl.pc_load   = 1'b1;
                ctl.pc_src    = PCS_ALU;
            end
            S_DECODE: begin
                ctl.alu_b_sel = BSEL_SHF;
                ctl.alu_mode  = AMODE_ADD;
            end
            S_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_mode  = AMODE_ADD;
            end
            S_LDMEM: begin
                ctl.mem_rd       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            S_LDWB: begin
                ctl.reg_wr      = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            S_STMEM: begin
                ctl.mem_wr       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            S_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_mode  = AMODE_FN;
            end
            S_RWB: begin
                ctl.reg_wr    = 1'b1;
                ctl.dst_is_rd = 1'b1;
            end
            S_BRANCH: begin
                ctl.alu_a_sel       = 1'b1;
                ctl.alu_b_sel       = BSEL_REG;
                ctl.alu_mode        = AMODE_SUB;
                ctl.pc_load_if_zero = 1'b1;
                ctl.pc_src          = PCS_OUT;
            end
            S_JUMP: begin
                ctl.pc_load = 1'b1;
                ctl.pc_src  = PCS_JMP;
            end
            S_BADOP, S_OVF: begin
                ctl.alu_b_sel  = BSEL_FOUR;
                ctl.alu_mode   = AMODE_SUB;
                ctl.epc_load   = 1'b1;
                ctl.pc_load    = 1'b1;
                ctl.pc_src     = PCS_EXC;
                ctl.cause_load = 1'b1;
                ctl.cause_code = (cur == S_OVF);
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mcc_top.sv
module mcc_top
    import mcc_pkg::*;
#(
    parameter int             OP_W     = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            overflow,
    output logic [3:0]      state_o,
    output logic            mem_addr_sel,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_load,
    output logic            wb_from_mem,
    output logic            dst_is_rd,
    output logic            reg_wr,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_mode,
    output logic            pc_load,
    output logic            pc_load_if_zero,
    output logic [1:0]      pc_src,
    output logic            epc_load,
    output logic            cause_load,
    output logic            cause_code
);
    iclass_e iclass;
    state_e  nxt;
    seq_t    seq_d, seq_q;
    ctl_t    ctl;

    mcc_class_dec #(
        .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
        .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
    ) u_dec (
        .opcode (opcode),
        .iclass (iclass)
    );

    mcc_next_state u_ns (
        .cur      (seq_q.st),
        .iclass   (iclass),
        .overflow (overflow),
        .nxt      (nxt)
    );

    mcc_out_dec u_out (
        .cur (seq_q.st),
        .ctl (ctl)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.st = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q.st <= S_FETCH;
        else     seq_q    <= seq_d;
    end

    assign state_o         = seq_q.st;
    assign mem_addr_sel    = ctl.mem_addr_sel;
    assign mem_rd          = ctl.mem_rd;
    assign mem_wr          = ctl.mem_wr;
    assign ir_load         = ctl.ir_load;
    assign wb_from_mem     = ctl.wb_from_mem;
    assign dst_is_rd       = ctl.dst_is_rd;
    assign reg_wr          = ctl.reg_wr;
    assign alu_a_sel       = ctl.alu_a_sel;
    assign alu_b_sel       = ctl.alu_b_sel;
    assign alu_mode        = ctl.alu_mode;
    assign pc_load         = ctl.pc_load;
    assign pc_load_if_zero = ctl.pc_load_if_zero;
    assign pc_src          = ctl.pc_src;
    assign epc_load        = ctl.epc_load;
    assign cause_load      = ctl.cause_load;
    assign cause_code      = ctl.cause_code;
endmodule

// File: rtl/mcc_chk.sv
module mcc_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] opcode,
    input logic       overflow,
    input logic [3:0] state_o,
    input logic       mem_addr_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       pc_load,
    input logic       pc_load_if_zero,
    input logic [1:0] pc_src,
    input logic       epc_load,
    input logic       cause_load,
    input logic       cause_code
);
    assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |=> state_o == 4'd1);

    assert_rtype_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 && opcode == 6'b000000) |=> state_o == 4'd6);

    assert_mem_rw_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_store_access_R6: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd5 |-> (mem_wr && mem_addr_sel));

    assert_ovf_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd7 && overflow) |=> state_o == 4'd11);

    assert_pc_write_kind_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_load, pc_load_if_zero}));

    assert_badop_cause_R11: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd10 |-> (cause_load && !cause_code && epc_load && pc_src == 2'b11));

    assert_ovf_cause_R12: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd11 |-> (cause_load && cause_code && epc_load) ##1 state_o == 4'd0);

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
        state_o <= 4'd11);
endmodule

bind mcc_top mcc_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .opcode          (opcode),
    .overflow        (overflow),
    .state_o         (state_o),
    .mem_addr_sel    (mem_addr_sel),
    .mem_rd          (mem_rd),
    .mem_wr          (mem_wr),
    .pc_load         (pc_load),
    .pc_load_if_zero (pc_load_if_zero),
    .pc_src          (pc_src),
    .epc_load        (epc_load),
    .cause_load      (cause_load),
    .cause_code      (cause_code)
);

// File: tb/tb_mcc_top.sv
module tb_mcc_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic       overflow = 1'b0;
    logic [3:0] state_o;
    logic mem_addr_sel, mem_rd, mem_wr, ir_load, wb_from_mem, dst_is_rd, reg_wr, alu_a_sel;
    logic [1:0] alu_b_sel, alu_mode, pc_src;
    logic pc_load, pc_load_if_zero, epc_load, cause_load, cause_code;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        int    st;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    mcc_top dut (
        .clk(clk), .rst(rst), .opcode(opcode), .overflow(overflow), .state_o(state_o),
        .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
        .wb_from_mem(wb_from_mem), .dst_is_rd(dst_is_rd), .reg_wr(reg_wr),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_mode(alu_mode),
        .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero), .pc_src(pc_src),
        .epc_load(epc_load), .cause_load(cause_load), .cause_code(cause_code)
    );

    // Field order: addr_sel rd wr ir wbmem dst regwr asel bsel(2) mode(2) pcl pclz src(2) epc cl code
    function automatic logic [20:0] expect_vec(input int s);
        logic as_ = 0, rd = 0, wr = 0, ir = 0, wm = 0, dr = 0, rw = 0, a = 0;
        logic [1:0] b = 0, m = 0, src = 0;
        logic pl = 0, plz = 0, ep = 0, cl = 0, cc = 0;
        case (s)
            0:  begin rd = 1; ir = 1; b = 2'b01; pl = 1; end
            1:  b = 2'b11;
            2:  begin a = 1; b = 2'b10; end
            3:  begin rd = 1; as_ = 1; end
            4:  begin rw = 1; wm = 1; end
            5:  begin wr = 1; as_ = 1; end
            6:  begin a = 1; m = 2'b10; end
            7:  begin rw = 1; dr = 1; end
            8:  begin a = 1; m = 2'b01; plz = 1; src = 2'b01; end
            9:  begin pl = 1; src = 2'b10; end
            10, 11: begin b = 2'b01; m = 2'b01; ep = 1; pl = 1; src = 2'b11; cl = 1; cc = (s == 11); end
            default: ;
        endcase
        return {as_, rd, wr, ir, wm, dr, rw, a, b, m, pl, plz, src, ep, cl, cc};
    endfunction

    function automatic logic [20:0] actual_vec();
        return {mem_addr_sel, mem_rd, mem_wr, ir_load, wb_from_mem, dst_is_rd, reg_wr,
                alu_a_sel, alu_b_sel, alu_mode, pc_load, pc_load_if_zero, pc_src,
                epc_load, cause_load, cause_code};
    endfunction

    task automatic check(input int st, input string req);
        tests++;
        if (state_o !== 4'(st) || actual_vec() !== expect_vec(st)) begin
            fails++;
            $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
                     req, state_o, actual_vec(), st, expect_vec(st));
        end
    endtask

    // Monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.st, e.req);
            end
        end
    end

    // Driver: called while the current cycle is fetch (state 0)
    task automatic run(input logic [5:0] op, input logic ov, input int seq[6],
                       input int n, input string req);
        opcode   = op;
        overflow = ov;
        for (int i = 0; i < n; i++) sb.push_back('{seq[i], req});
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(0, "R1 reset state");
        @(posedge clk);
        #1 rst = 1'b0;

        run(6'b100011, 1'b0, '{0,1,2,3,4,0}, 5, "R5 load path R4");
        run(6'b101011, 1'b0, '{0,1,2,5,0,0}, 4, "R6 store path R4");
        run(6'b000000, 1'b0, '{0,1,6,7,0,0}, 4, "R7 register arithmetic");
        run(6'b000100, 1'b0, '{0,1,8,0,0,0}, 3, "R9 branch R3");
        run(6'b000010, 1'b0, '{0,1,9,0,0,0}, 3, "R10 jump R3");
        run(6'b111111, 1'b0, '{0,1,10,0,0,0}, 3, "R11 undefined 111111");
        run(6'b001000, 1'b0, '{0,1,10,0,0,0}, 3, "R11 undefined 001000");
        run(6'b000000, 1'b1, '{0,1,6,7,11,0}, 5, "R12 overflow trap R8");
        run(6'b100011, 1'b1, '{0,1,2,3,4,0}, 5, "R8 overflow ignored on load");
        run(6'b000010, 1'b1, '{0,1,9,0,0,0}, 3, "R8 overflow ignored on jump");
        run(6'b000000, 1'b0, '{0,1,6,7,0,0}, 4, "R2 fetch after exception");

        // Mid-instruction reset: after load reaches state 3, reset returns to fetch
        opcode = 6'b100011; overflow = 1'b0;
        for (int i = 0; i < 3; i++) sb.push_back('{i, "R1 pre-reset"});
        repeat (3) @(posedge clk);
        #1 rst = 1'b1;
        sb.push_back('{3, "R1 pre-reset"});
        @(posedge clk);
        #1 rst = 1'b0;
        sb.push_back('{0, "R1 reset from state 3"});
        @(posedge clk);
        #1;
        run(6'b101011, 1'b0, '{1,2,5,0,0,0}, 3, "R6 store after reset");

        @(negedge clk);
        if (sb.size() != 0) begin
            tests++; fails++;
            $display("FAIL R2: %0d expected items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R2: watchdog expired, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule